// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block is the state keeper for the clock and power modes of a small microcontroller. It follows the CPU clock source and speed through main-clock divide-by-8, high speed, medium speed, PLL, low speed, low power and on-chip oscillator operation. It also covers the two halted states: wait, where only the CPU clock is gated, and stop, where every oscillator is off. Software drives it through a combined 16-bit control write and a separate auxiliary write. The core raises a strobe when it executes a wait instruction, and the interrupt controller wakes the block.

The controller applies the legality rules between modes. The PLL is reachable only through high speed, and wait or stop cannot be entered while the PLL drives the CPU. A stop request is refused while oscillation-stop detection is enabled. A refused request leaves every piece of state unchanged and raises a one-cycle error pulse. The outputs are the oscillator enables, the CPU clock gate and the divider select. The actual oscillators, the PLL lock and the clock multiplexers sit outside the block. When the block leaves stop, it keeps the CPU gated for a parameterised settle time, then resumes from the main clock.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset the mode is main divide-by-8 (mode code 0), the divider select is 3 (divide by 8), the CPU clock is enabled, only the main oscillator is enabled, and the error output is 0.
- R2: A control write (`ctl_wr_i`) carries the requested run mode in bits [2:0] and a stop request in bit 3. The bits [2:0] select: 0 main divide-by-8 (mode 0, divider 3), 1 high speed (mode 1, divider 0), 2/3/4 medium speed (mode 2, divider 1/2/4), 5 PLL (mode 3, divider 0), 6 low speed (mode 4, divider 0), 7 low power (mode 5, divider 0). A write with any of bits [15:4] set is refused with an error.
- R3: A PLL request is accepted only in high-speed or PLL mode. From any other mode it is refused with an error and the mode is kept.
- R4: In PLL mode, the only accepted requests are high speed and PLL. A request for any other run mode, stop, wait, or on-chip oscillator selection is refused with an error, and the block stays in PLL mode.
- R5: `wait_i` in any run mode other than PLL enters wait (mode 7). The CPU clock is gated off and the oscillator enables stay as they were in the mode that was left.
- R6: `irq_i` in wait returns to the mode that was left, with the CPU clock enabled on the next cycle.
- R7: A stop request enters stop (mode 8) with every oscillator and the CPU clock disabled. The request is refused with an error while the oscillation-stop-detect enable (auxiliary bit 1) is 1.
- R8: `irq_i` in stop enters settle (mode 9) for exactly SETTLE_CYC cycles, with only the main oscillator on and the CPU gated. After that the block enters main divide-by-8 (mode 0, divider 3).
- R9: An auxiliary write with bit 0 = 1 enters on-chip oscillator mode (mode 6, divider 3, only the on-chip oscillator enabled). While that bit is 1, control writes are ignored with no error. Clearing the bit returns to mode 0.
- R10: The error output is a single-cycle pulse for each refused request. In a run mode, an auxiliary write takes priority over a control write, and a control write takes priority over `wait_i`. In wait, stop and settle, only `irq_i` has an effect.
- R11: `irq_i` in a run mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Combined 16-bit control write strobe |
| ctl_data_i | input | 16 | Control word: [2:0] run mode request, [3] stop request, [15:4] reserved zero |
| aux_wr_i | input | 1 | Auxiliary write strobe |
| aux_data_i | input | 2 | [0] on-chip oscillator select, [1] oscillation-stop-detect enable |
| wait_i | input | 1 | Wait instruction strobe |
| irq_i | input | 1 | Interrupt request (wake) |
| mode_o | output | 4 | Current mode code |
| div_sel_o | output | 3 | CPU divider: 0=/1, 1=/2, 2=/4, 3=/8, 4=/16 |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub oscillator enable |
| oco_en_o | output | 1 | On-chip oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| err_o | output | 1 | Refused request pulse |

## Verification
The assertions check these properties on every cycle:
- PLL is entered only from high speed and left only to high speed.
- Wait in PLL mode stays put and flags an error.
- Stop disables every oscillator.
- The CPU gate is off in wait and settle.
- The settle window never exceeds SETTLE_CYC and ends in main divide-by-8.
- An error never coincides with a mode change.

Only the bench scenarios can show the rest:
- The complete legality matrix over every starting mode, request code, stop bit and detect-enable value.
- The exact divider codes.
- The return to the saved mode after wait.
- That writes issued during wait or in on-chip oscillator mode leave no trace.
- The input priority order.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
  localparam int unsigned CTL_W = 16;
  localparam int unsigned REQ_W = 3;
  localparam int unsigned STOP_BIT = 3;

  typedef enum logic [3:0] {
    M_MID8   = 4'd0,
    M_HIGH   = 4'd1,
    M_MID    = 4'd2,
    M_PLL    = 4'd3,
    M_LOW    = 4'd4,
    M_LOWPWR = 4'd5,
    M_OCO    = 4'd6,
    M_WAIT   = 4'd7,
    M_STOP   = 4'd8,
    M_SETTLE = 4'd9
  } mode_e;

  typedef enum logic [2:0] {
    D1  = 3'd0,
    D2  = 3'd1,
    D4  = 3'd2,
    D8  = 3'd3,
    D16 = 3'd4
  } div_e;

  function automatic logic is_run(mode_e m);
    return m <= M_OCO;
  endfunction
endpackage

// File: rtl/clk_pwr_legal.sv
module clk_pwr_legal
  import clk_pwr_pkg::*;
(
  input  mode_e             mode_i,
  input  div_e              div_i,
  input  logic              osd_en_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output mode_e             tgt_mode_o,
  output div_e              tgt_div_o,
  output logic              refuse_o
);
  logic [REQ_W-1:0] req;
  logic             stop_req;
  logic             rsvd_set;

  assign req      = ctl_i[REQ_W-1:0];
  assign stop_req = ctl_i[STOP_BIT];
  assign rsvd_set = |ctl_i[CTL_W-1:STOP_BIT+1];

  always_comb begin
    unique case (req)
      3'd0:    begin tgt_mode_o = M_MID8;   tgt_div_o = D8;  end
      3'd1:    begin tgt_mode_o = M_HIGH;   tgt_div_o = D1;  end
      3'd2:    begin tgt_mode_o = M_MID;    tgt_div_o = D2;  end
      3'd3:    begin tgt_mode_o = M_MID;    tgt_div_o = D4;  end
      3'd4:    begin tgt_mode_o = M_MID;    tgt_div_o = D16; end
      3'd5:    begin tgt_mode_o = M_PLL;    tgt_div_o = D1;  end
      3'd6:    begin tgt_mode_o = M_LOW;    tgt_div_o = D1;  end
      default: begin tgt_mode_o = M_LOWPWR; tgt_div_o = D1;  end
    endcase
    refuse_o = rsvd_set;
    if (stop_req) begin
      tgt_mode_o = M_STOP;
      tgt_div_o  = div_i;
      refuse_o   = refuse_o || (mode_i == M_PLL) || osd_en_i;
    end else begin
      // PLL only reachable through high speed, and only left to high speed
      if (tgt_mode_o == M_PLL && !(mode_i == M_HIGH || mode_i == M_PLL))
        refuse_o = 1'b1;
      if (mode_i == M_PLL && !(tgt_mode_o == M_HIGH || tgt_mode_o == M_PLL))
        refuse_o = 1'b1;
    end
  end
endmodule

// File: rtl/clk_pwr_settle.sv
module clk_pwr_settle #(
  parameter int unsigned SETTLE_CYC = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/clk_pwr_outmap.sv
module clk_pwr_outmap
  import clk_pwr_pkg::*;
(
  input  mode_e mode_i,
  input  mode_e saved_i,
  output logic  cpu_en_o,
  output logic  main_en_o,
  output logic  sub_en_o,
  output logic  oco_en_o,
  output logic  pll_en_o
);
  mode_e eff;

  // wait keeps the oscillators of the mode it was entered from
  assign eff      = (mode_i == M_WAIT) ? saved_i : mode_i;
  assign cpu_en_o = is_run(mode_i);

  always_comb begin
    main_en_o = 1'b0;
    sub_en_o  = 1'b0;
    oco_en_o  = 1'b0;
    pll_en_o  = 1'b0;
    unique case (eff)
      M_MID8, M_HIGH, M_MID, M_SETTLE: main_en_o = 1'b1;
      M_PLL:    begin main_en_o = 1'b1; pll_en_o = 1'b1; end
      M_LOW:    begin main_en_o = 1'b1; sub_en_o = 1'b1; end
      M_LOWPWR: sub_en_o = 1'b1;
      M_OCO:    oco_en_o = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clk_pwr_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 256
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctl_wr_i,
  input  logic [15:0] ctl_data_i,
  input  logic        aux_wr_i,
  input  logic [1:0]  aux_data_i,
  input  logic        wait_i,
  input  logic        irq_i,
  output logic [3:0]  mode_o,
  output logic [2:0]  div_sel_o,
  output logic        cpu_clk_en_o,
  output logic        main_osc_en_o,
  output logic        sub_osc_en_o,
  output logic        oco_en_o,
  output logic        pll_en_o,
  output logic        err_o
);
  mode_e mode_q, mode_d, saved_q, saved_d, tgt_mode;
  div_e  div_q, div_d, tgt_div;
  logic  oco_q, oco_d, osd_q, osd_d, err_q, err_d;
  logic  refuse, settle_done;

  clk_pwr_legal u_legal (
    .mode_i     (mode_q),
    .div_i      (div_q),
    .osd_en_i   (osd_q),
    .ctl_i      (ctl_data_i),
    .tgt_mode_o (tgt_mode),
    .tgt_div_o  (tgt_div),
    .refuse_o   (refuse)
  );

  clk_pwr_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (mode_q == M_SETTLE),
    .done_o (settle_done)
  );

  clk_pwr_outmap u_map (
    .mode_i    (mode_q),
    .saved_i   (saved_q),
    .cpu_en_o  (cpu_clk_en_o),
    .main_en_o (main_osc_en_o),
    .sub_en_o  (sub_osc_en_o),
    .oco_en_o  (oco_en_o),
    .pll_en_o  (pll_en_o)
  );

  always_comb begin
    mode_d  = mode_q;
    saved_d = saved_q;
    div_d   = div_q;
    oco_d   = oco_q;
    osd_d   = osd_q;
    err_d   = 1'b0;
    if (is_run(mode_q)) begin
      if (aux_wr_i) begin
        if (mode_q == M_PLL && aux_data_i[0]) begin
          err_d = 1'b1;
        end else begin
          oco_d = aux_data_i[0];
          osd_d = aux_data_i[1];
          if (aux_data_i[0] && !oco_q) begin
            mode_d = M_OCO;
            div_d  = D8;
          end else if (!aux_data_i[0] && oco_q) begin
            mode_d = M_MID8;
            div_d  = D8;
          end
        end
      end else if (ctl_wr_i && !oco_q) begin
        if (refuse) err_d = 1'b1;
        else begin
          mode_d = tgt_mode;
          div_d  = tgt_div;
        end
      end else if (wait_i) begin
        if (mode_q == M_PLL) err_d = 1'b1;
        else begin
          saved_d = mode_q;
          mode_d  = M_WAIT;
        end
      end
    end else begin
      unique case (mode_q)
        M_WAIT: if (irq_i) mode_d = saved_q;
        M_STOP: if (irq_i) mode_d = M_SETTLE;
        M_SETTLE: if (settle_done) begin
          mode_d = M_MID8;
          div_d  = D8;
          oco_d  = 1'b0;
        end
        default: mode_d = M_MID8;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_MID8;
      saved_q <= M_MID8;
      div_q   <= D8;
      oco_q   <= 1'b0;
      osd_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      saved_q <= saved_d;
      div_q   <= div_d;
      oco_q   <= oco_d;
      osd_q   <= osd_d;
      err_q   <= err_d;
    end
  end

  assign mode_o    = mode_q;
  assign div_sel_o = div_q;
  assign err_o     = err_q;
endmodule

// File: rtl/clk_pwr_ctrl_chk.sv
module clk_pwr_ctrl_chk
  import clk_pwr_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 256
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctl_wr_i,
  input logic       aux_wr_i,
  input logic       wait_i,
  input logic       irq_i,
  input logic [3:0] mode_o,
  input logic [2:0] div_sel_o,
  input logic       cpu_clk_en_o,
  input logic       main_osc_en_o,
  input logic       sub_osc_en_o,
  input logic       oco_en_o,
  input logic       pll_en_o,
  input logic       err_o
);
  int unsigned settle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 settle_cnt <= 0;
    else if (mode_o == M_SETTLE) settle_cnt <= settle_cnt + 1;
    else                         settle_cnt <= 0;
  end

  // R3
  pll_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_PLL && $past(mode_o) != M_PLL) |-> $past(mode_o) == M_HIGH);
  // R4
  pll_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_PLL && mode_o != M_PLL) |-> mode_o == M_HIGH);
  // R4
  pll_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_PLL && wait_i && !ctl_wr_i && !aux_wr_i) |=> (mode_o == M_PLL && err_o));
  // R5
  halt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_WAIT || mode_o == M_SETTLE) |-> !cpu_clk_en_o);
  // R6
  wait_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_WAIT && irq_i) |=> cpu_clk_en_o);
  // R7
  stop_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_STOP) |-> !(main_osc_en_o || sub_osc_en_o || oco_en_o || pll_en_o || cpu_clk_en_o));
  // R8
  stop_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_STOP && mode_o != M_STOP) |-> (mode_o == M_SETTLE && main_osc_en_o));
  // R8
  settle_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_SETTLE) |-> settle_cnt < SETTLE_CYC);
  // R8
  settle_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == M_SETTLE && mode_o != M_SETTLE) |-> (mode_o == M_MID8 && $past(settle_cnt) == SETTLE_CYC - 1));
  // R9
  oco_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_OCO) |-> (div_sel_o == D8 && oco_en_o && !main_osc_en_o));
  // R10
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(mode_o));
endmodule

bind clk_pwr_ctrl clk_pwr_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctl_wr_i      (ctl_wr_i),
  .aux_wr_i      (aux_wr_i),
  .wait_i        (wait_i),
  .irq_i         (irq_i),
  .mode_o        (mode_o),
  .div_sel_o     (div_sel_o),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .main_osc_en_o (main_osc_en_o),
  .sub_osc_en_o  (sub_osc_en_o),
  .oco_en_o      (oco_en_o),
  .pll_en_o      (pll_en_o),
  .err_o         (err_o)
);

// File: tb/clk_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module clk_pwr_ctrl_bench;
  localparam int SC = 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [15:0] ctl_data = '0;
  logic        aux_wr = 1'b0;
  logic [1:0]  aux_data = '0;
  logic        wait_s = 1'b0;
  logic        irq = 1'b0;
  logic [3:0]  mode;
  logic [2:0]  div;
  logic        cpu_en, main_en, sub_en, oco_en, pll_en, err;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  clk_pwr_ctrl #(.SETTLE_CYC(SC)) u_clk_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr), .ctl_data_i(ctl_data),
    .aux_wr_i(aux_wr), .aux_data_i(aux_data), .wait_i(wait_s), .irq_i(irq),
    .mode_o(mode), .div_sel_o(div), .cpu_clk_en_o(cpu_en),
    .main_osc_en_o(main_en), .sub_osc_en_o(sub_en), .oco_en_o(oco_en),
    .pll_en_o(pll_en), .err_o(err)
  );

  function automatic int tmode(int code);
    case (code)
      0: return 0;
      1: return 1;
      2, 3, 4: return 2;
      5: return 3;
      6: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int tdiv(int code);
    case (code)
      0: return 3;
      2: return 1;
      3: return 2;
      4: return 4;
      default: return 0;
    endcase
  endfunction

  // {main,sub,oco,pll}
  function automatic int osc(int m, int saved);
    case (m)
      0, 1, 2, 9: return 8;
      3: return 9;
      4: return 12;
      5: return 4;
      6: return 2;
      7: return osc(saved, 0);
      default: return 0;
    endcase
  endfunction

  function automatic int osc_now();
    return {28'd0, main_en, sub_en, oco_en, pll_en};
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step();
    step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic wr(int code, bit stop);
    ctl_wr = 1'b1;
    ctl_data = {12'd0, stop, code[2:0]};
    step();
    ctl_wr = 1'b0;
    ctl_data = '0;
  endtask

  task automatic aux(bit oco_sel, bit osd);
    aux_wr = 1'b1;
    aux_data = {osd, oco_sel};
    step();
    aux_wr = 1'b0;
  endtask

  task automatic pulse_wait();
    wait_s = 1'b1;
    step();
    wait_s = 1'b0;
  endtask

  task automatic pulse_irq();
    irq = 1'b1;
    step();
    irq = 1'b0;
  endtask

  task automatic reach(int fcode);
    if (fcode == 5) begin
      wr(1, 1'b0);
      wr(5, 1'b0);
    end else begin
      wr(fcode, 1'b0);
    end
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int fcodes[6] = '{0, 1, 2, 5, 6, 7};
    do_reset();
    // R1
    chk("R1 mode", mode, 0);
    chk("R1 div", div, 3);
    chk("R1 cpu", cpu_en, 1);
    chk("R1 osc", osc_now(), 8);
    chk("R1 err", err, 0);

    // R2 R3 R4 R7: legality sweep
    for (int fi = 0; fi < 6; fi++)
      for (int code = 0; code < 8; code++)
        for (int st = 0; st < 2; st++)
          for (int od = 0; od < 2; od++) begin
            int fm, fd, em, ed;
            bit refuse;
            do_reset();
            aux(1'b0, od[0]);
            reach(fcodes[fi]);
            fm = tmode(fcodes[fi]);
            fd = tdiv(fcodes[fi]);
            if (st != 0) begin
              refuse = (fm == 3) || (od != 0);
              em = refuse ? fm : 8;
              ed = fd;
            end else begin
              em = tmode(code);
              refuse = (em == 3 && !(fm == 1 || fm == 3)) || (fm == 3 && !(em == 1 || em == 3));
              ed = refuse ? fd : tdiv(code);
              if (refuse) em = fm;
            end
            wr(code, st[0]);
            chk(st != 0 ? "R7 stop mode" : (fm == 3 ? "R4 mode" : "R3 R2 mode"), mode, em);
            chk("R2 div", div, ed);
            chk(st != 0 ? "R7 err" : "R3 R4 err", err, refuse);
            chk("R7 R2 osc", osc_now(), osc(em, 0));
            step();
            chk("R10 err pulse", err, 0);
          end

    // R2 reserved bits
    do_reset();
    ctl_wr = 1'b1; ctl_data = 16'h0011; step(); ctl_wr = 1'b0; ctl_data = '0;
    chk("R2 rsvd mode", mode, 0);
    chk("R2 rsvd err", err, 1);

    // R5 R6 wait from each run mode
    for (int code = 0; code < 9; code++) begin
      int m, d;
      if (code == 5) continue;
      do_reset();
      if (code == 8) begin aux(1'b1, 1'b0); m = 6; d = 3; end
      else begin reach(code); m = tmode(code); d = tdiv(code); end
      pulse_wait();
      chk("R5 wait mode", mode, 7);
      chk("R5 cpu off", cpu_en, 0);
      chk("R5 osc kept", osc_now(), osc(m, 0));
      wr(1, 1'b0);
      chk("R10 ctl in wait", mode, 7);
      chk("R10 ctl in wait err", err, 0);
      pulse_irq();
      chk("R6 back", mode, m);
      chk("R6 cpu on", cpu_en, 1);
      chk("R6 div", div, d);
    end

    // R4 wait and oco select from PLL
    do_reset();
    reach(5);
    pulse_wait();
    chk("R4 wait pll mode", mode, 3);
    chk("R4 wait pll err", err, 1);
    aux(1'b1, 1'b0);
    chk("R4 oco pll mode", mode, 3);
    chk("R4 oco pll err", err, 1);

    // R11
    do_reset();
    wr(1, 1'b0);
    pulse_irq();
    chk("R11 irq run mode", mode, 1);
    chk("R11 irq run err", err, 0);

    // R9
    do_reset();
    aux(1'b1, 1'b0);
    chk("R9 oco mode", mode, 6);
    chk("R9 oco div", div, 3);
    chk("R9 oco osc", osc_now(), 2);
    wr(1, 1'b0);
    chk("R9 ctl ignored", mode, 6);
    chk("R9 ctl no err", err, 0);
    wr(0, 1'b1);
    chk("R9 stop ignored", mode, 6);
    aux(1'b0, 1'b0);
    chk("R9 back main", mode, 0);
    chk("R9 back div", div, 3);

    // R10 priority
    do_reset();
    ctl_wr = 1'b1; ctl_data = 16'h0001; wait_s = 1'b1; step();
    ctl_wr = 1'b0; ctl_data = '0; wait_s = 1'b0;
    chk("R10 ctl over wait", mode, 1);
    aux_wr = 1'b1; aux_data = 2'b01; ctl_wr = 1'b1; ctl_data = 16'h0006; step();
    aux_wr = 1'b0; ctl_wr = 1'b0; ctl_data = '0;
    chk("R10 aux over ctl", mode, 6);

    // R8 stop and settle
    do_reset();
    wr(2, 1'b0);
    wr(0, 1'b1);
    chk("R7 stop", mode, 8);
    chk("R7 stop cpu", cpu_en, 0);
    chk("R7 stop osc", osc_now(), 0);
    pulse_wait();
    chk("R10 wait in stop", mode, 8);
    step();
    chk("R8 stays stopped", mode, 8);
    pulse_irq();
    begin
      int n = 0;
      int bad = 0;
      while (mode == 9 && n < 2 * SC) begin
        if (cpu_en || osc_now() != 8) bad++;
        step();
        n++;
      end
      chk("R8 settle length", n, SC);
      chk("R8 settle gated", bad, 0);
    end
    chk("R8 resume mode", mode, 0);
    chk("R8 resume div", div, 3);
    chk("R8 resume cpu", cpu_en, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule